// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block runs complete 16-bit register transactions on an I2C bus. It does not drive the bus pins. Instead it sits on top of a byte-level master engine and issues that engine's commands one at a time: start, write byte, read byte with ACK, read byte with NACK, and stop. After each command it waits for the engine's completion status and compares it with the one status that step allows. A host supplies a 7-bit slave address, a command byte, a direction and, for writes, a 16-bit value. The host receives a single done pulse, a success flag and, for reads, the two received bytes.

A write sends the address with the direction bit cleared, then the command byte, the high byte and the low byte, and then a STOP. A read sends the address for writing and the command byte. It then issues a repeated START and the address with the direction bit set. It reads the high byte and answers it with ACK, reads the low byte and answers it with NACK, and finishes with a STOP. Any status that is out of sequence ends the transfer early through a STOP, so the bus is always released. The one exception is a failed opening START: the bus was never taken, so no STOP is sent.

Top module: `i2c_reg_seq`

## Requirements
- R1: After reset, `busy`, `done`, `ok` and `eng_go` are 0 and `rdata` is 0.
- R2: The address byte on `eng_wbyte` is `{addr, dir}`: the slave address in bits 7..1 and the direction in bit 0, where 0 means write and 1 means read.
- R3: A write (`rd_wr`=0) issues, in this order: START (op 0), address+W (op 1), `cmd` (op 1), `wdata[15:8]` (op 1), `wdata[7:0]` (op 1), then STOP (op 4). Each byte write expects status 3 for the address and status 4 for data bytes.
- R4: A read (`rd_wr`=1) issues, in this order: START, address+W, `cmd`, START again (which must return status 2, repeated start), address+R, read-with-ACK (op 2, expects status 5), read-with-NACK (op 3, expects status 6), then STOP. On success `rdata` = {first byte, second byte}.
- R5: The first START accepts either status 1 (start) or status 2 (repeated start). Any other status ends the transfer with `done`=1 and `ok`=0, and no further `eng_go` occurs, including no STOP.
- R6: After any later step, a status other than the expected one makes the very next command a STOP, and the transfer completes with `ok`=0.
- R7: A transfer in which every status matches ends with a STOP and `ok`=1.
- R8: The STOP is not awaited. `done` pulses for one cycle, in the cycle right after the STOP's `eng_go` cycle, with `busy` already 0.
- R9: `eng_go` is a one-cycle pulse, and the next command is issued only after `eng_done` has reported on the previous one.
- R10: `req` is ignored while `busy` is 1. `eng_done` is ignored while no command is outstanding.
- R11: `rdata` is cleared when a request is accepted. A received byte is stored only when its matching status (5 or 6) arrives, so a failed read keeps 0 in every byte that was not properly received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req | input | 1 | Start a transaction (sampled when idle) |
| rd_wr | input | 1 | 1 = register read, 0 = register write |
| addr | input | 7 | Slave address |
| cmd | input | 8 | Command (register select) byte |
| wdata | input | 16 | Value to write, high byte first |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Success flag, valid with `done` |
| rdata | output | 16 | Read result, valid with `done` |
| eng_go | output | 1 | Command strobe to the byte engine |
| eng_op | output | 3 | Command: 0 start, 1 write byte, 2 read+ACK, 3 read+NACK, 4 stop |
| eng_wbyte | output | 8 | Byte to transmit for op 1 |
| eng_done | input | 1 | Engine completion pulse |
| eng_status | input | 3 | 0 lost, 1 start, 2 repeated start, 3 address ACKed, 4 data ACKed, 5 byte received+ACK, 6 byte received+NACK, 7 NACK received |
| eng_rbyte | input | 8 | Received byte, valid with `eng_done` |

## Verification
The assertions check, on every cycle, how strobes and completion relate in time. `eng_go` never lasts more than one cycle. A STOP is always followed by a done pulse one cycle later while idle, and a successful done is always preceded by a STOP. Every transaction opens with a START, and an idle controller stays idle without a request. The bench scenarios are needed for the rest: the exact order and contents of the command stream for reads and writes, the abort point for each failing step, the absence of a STOP after a failed opening, the partial capture of read data, and requests and completions that arrive at the wrong time and must be ignored.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_WRITE   = 3'd1,
        OP_RD_ACK  = 3'd2,
        OP_RD_NACK = 3'd3,
        OP_STOP    = 3'd4
    } eng_op_e;

    typedef enum logic [2:0] {
        ST_LOST     = 3'd0,
        ST_START    = 3'd1,
        ST_RESTART  = 3'd2,
        ST_ADDR_ACK = 3'd3,
        ST_DATA_ACK = 3'd4,
        ST_RX_ACK   = 3'd5,
        ST_RX_NACK  = 3'd6,
        ST_NACK     = 3'd7
    } eng_st_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_STOP  = 2'd3
    } seq_state_e;

    localparam int STEP_W = 3;

endpackage

// File: rtl/i2c_seq_step.sv
// Step table: maps (direction, step index) to the engine command,
// the byte to send, and the only status that step accepts.
module i2c_seq_step
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic                  rd,
    input  logic [STEP_W-1:0]     step,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     cmd,
    input  logic [2*BYTE_W-1:0]   wdata,
    output eng_op_e               op,
    output logic [BYTE_W-1:0]     wbyte,
    output eng_st_e               exp_st,
    output logic                  alt_ok,
    output logic                  last,
    output logic                  cap_hi,
    output logic                  cap_lo
);

    always_comb begin
        op     = OP_START;
        wbyte  = '0;
        exp_st = ST_START;
        alt_ok = 1'b0;
        last   = 1'b0;
        cap_hi = 1'b0;
        cap_lo = 1'b0;
        case (step)
            3'd0: begin
                op     = OP_START;
                exp_st = ST_START;
                alt_ok = 1'b1;
            end
            3'd1: begin
                op     = OP_WRITE;
                wbyte  = {addr, 1'b0};
                exp_st = ST_ADDR_ACK;
            end
            3'd2: begin
                op     = OP_WRITE;
                wbyte  = cmd;
                exp_st = ST_DATA_ACK;
            end
            3'd3: begin
                if (rd) begin
                    op     = OP_START;
                    exp_st = ST_RESTART;
                end else begin
                    op     = OP_WRITE;
                    wbyte  = wdata[2*BYTE_W-1:BYTE_W];
                    exp_st = ST_DATA_ACK;
                end
            end
            3'd4: begin
                op = OP_WRITE;
                if (rd) begin
                    wbyte  = {addr, 1'b1};
                    exp_st = ST_ADDR_ACK;
                end else begin
                    wbyte  = wdata[BYTE_W-1:0];
                    exp_st = ST_DATA_ACK;
                    last   = 1'b1;
                end
            end
            3'd5: begin
                op     = OP_RD_ACK;
                exp_st = ST_RX_ACK;
                cap_hi = 1'b1;
            end
            3'd6: begin
                op     = OP_RD_NACK;
                exp_st = ST_RX_NACK;
                cap_lo = 1'b1;
                last   = 1'b1;
            end
            default: begin
                op     = OP_STOP;
                exp_st = ST_LOST;
            end
        endcase
    end

endmodule

// File: rtl/i2c_seq_ctl.sv
// Transaction state machine: issues one command, waits for its status,
// advances or aborts through STOP.
module i2c_seq_ctl
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  rd_wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     cmd,
    input  logic [2*BYTE_W-1:0]   wdata,
    input  logic                  eng_done,
    input  eng_st_e               eng_st,
    input  eng_st_e               exp_st,
    input  logic                  alt_ok,
    input  logic                  last,
    input  logic                  step_cap_hi,
    input  logic                  step_cap_lo,
    output logic                  rd_q,
    output logic [STEP_W-1:0]     step_q,
    output logic [ADDR_W-1:0]     addr_q,
    output logic [BYTE_W-1:0]     cmd_q,
    output logic [2*BYTE_W-1:0]   wdata_q,
    output logic                  go,
    output logic                  stopping,
    output logic                  clr,
    output logic                  cap_hi,
    output logic                  cap_lo,
    output logic                  busy,
    output logic                  done,
    output logic                  ok
);

    typedef struct packed {
        seq_state_e            state;
        logic [STEP_W-1:0]     step;
        logic                  rd;
        logic [ADDR_W-1:0]     addr;
        logic [BYTE_W-1:0]     cmd;
        logic [2*BYTE_W-1:0]   wdata;
        logic                  ok;
        logic                  done;
    } ctl_t;

    ctl_t s_d, s_q;
    logic hit;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        clr      = 1'b0;
        cap_hi   = 1'b0;
        cap_lo   = 1'b0;
        hit      = (eng_st == exp_st) || (alt_ok && eng_st == ST_RESTART);
        case (s_q.state)
            SQ_IDLE: begin
                if (req) begin
                    s_d.state = SQ_ISSUE;
                    s_d.step  = '0;
                    s_d.rd    = rd_wr;
                    s_d.addr  = addr;
                    s_d.cmd   = cmd;
                    s_d.wdata = wdata;
                    s_d.ok    = 1'b0;
                    clr       = 1'b1;
                end
            end
            SQ_ISSUE: s_d.state = SQ_WAIT;
            SQ_WAIT: begin
                if (eng_done) begin
                    if (hit) begin
                        cap_hi = step_cap_hi;
                        cap_lo = step_cap_lo;
                        if (last) begin
                            s_d.state = SQ_STOP;
                            s_d.ok    = 1'b1;
                        end else begin
                            s_d.state = SQ_ISSUE;
                            s_d.step  = s_q.step + 1'b1;
                        end
                    end else if (s_q.step == '0) begin
                        s_d.state = SQ_IDLE;
                        s_d.done  = 1'b1;
                        s_d.ok    = 1'b0;
                    end else begin
                        s_d.state = SQ_STOP;
                        s_d.ok    = 1'b0;
                    end
                end
            end
            SQ_STOP: begin
                s_d.state = SQ_IDLE;
                s_d.done  = 1'b1;
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_q     = s_q.rd;
    assign step_q   = s_q.step;
    assign addr_q   = s_q.addr;
    assign cmd_q    = s_q.cmd;
    assign wdata_q  = s_q.wdata;
    assign go       = (s_q.state == SQ_ISSUE) || (s_q.state == SQ_STOP);
    assign stopping = (s_q.state == SQ_STOP);
    assign busy     = (s_q.state != SQ_IDLE);
    assign done     = s_q.done;
    assign ok       = s_q.ok;

endmodule

// File: rtl/i2c_seq_rcap.sv
// Read-data holding register: cleared on accept, written per byte.
module i2c_seq_rcap #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  cap_hi,
    input  logic                  cap_lo,
    input  logic [BYTE_W-1:0]     byte_in,
    output logic [2*BYTE_W-1:0]   rdata
);

    logic [2*BYTE_W-1:0] r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d = '0;
        end else begin
            if (cap_hi) r_d[2*BYTE_W-1:BYTE_W] = byte_in;
            if (cap_lo) r_d[BYTE_W-1:0]        = byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q;

endmodule

// File: rtl/i2c_reg_seq.sv
module i2c_reg_seq
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 rd_wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    cmd,
    input  logic [WORD_W-1:0]    wdata,
    output logic                 busy,
    output logic                 done,
    output logic                 ok,
    output logic [WORD_W-1:0]    rdata,
    output logic                 eng_go,
    output logic [2:0]           eng_op,
    output logic [BYTE_W-1:0]    eng_wbyte,
    input  logic                 eng_done,
    input  logic [2:0]           eng_status,
    input  logic [BYTE_W-1:0]    eng_rbyte
);

    logic                rd_q;
    logic [STEP_W-1:0]   step_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BYTE_W-1:0]   cmd_q;
    logic [WORD_W-1:0]   wdata_q;
    eng_op_e             step_op;
    logic [BYTE_W-1:0]   step_byte;
    eng_st_e             exp_st;
    logic                alt_ok, last, step_cap_hi, step_cap_lo;
    logic                stopping, clr, cap_hi, cap_lo;

    i2c_seq_step #(.ADDR_W(ADDR_W)) u_step (
        .rd     (rd_q),
        .step   (step_q),
        .addr   (addr_q),
        .cmd    (cmd_q),
        .wdata  (wdata_q),
        .op     (step_op),
        .wbyte  (step_byte),
        .exp_st (exp_st),
        .alt_ok (alt_ok),
        .last   (last),
        .cap_hi (step_cap_hi),
        .cap_lo (step_cap_lo)
    );

    i2c_seq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .rd_wr       (rd_wr),
        .addr        (addr),
        .cmd         (cmd),
        .wdata       (wdata),
        .eng_done    (eng_done),
        .eng_st      (eng_st_e'(eng_status)),
        .exp_st      (exp_st),
        .alt_ok      (alt_ok),
        .last        (last),
        .step_cap_hi (step_cap_hi),
        .step_cap_lo (step_cap_lo),
        .rd_q        (rd_q),
        .step_q      (step_q),
        .addr_q      (addr_q),
        .cmd_q       (cmd_q),
        .wdata_q     (wdata_q),
        .go          (eng_go),
        .stopping    (stopping),
        .clr         (clr),
        .cap_hi      (cap_hi),
        .cap_lo      (cap_lo),
        .busy        (busy),
        .done        (done),
        .ok          (ok)
    );

    i2c_seq_rcap #(.BYTE_W(BYTE_W)) u_rcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .cap_hi  (cap_hi),
        .cap_lo  (cap_lo),
        .byte_in (eng_rbyte),
        .rdata   (rdata)
    );

    assign eng_op    = stopping ? OP_STOP : step_op;
    assign eng_wbyte = stopping ? '0 : step_byte;

endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       busy,
    input logic       done,
    input logic       ok,
    input logic       eng_go,
    input logic [2:0] eng_op
);

    // R9: command strobe is a single-cycle pulse
    a_r9_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |=> !eng_go);

    // R9: no command is issued while idle
    a_r9_no_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_go);

    // R8: STOP is not awaited, completion follows at once
    a_r8_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_go && eng_op == 3'd4) |=> (done && !busy));

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: success is only reported after a STOP
    a_r7_ok_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> $past(eng_go && eng_op == 3'd4));

    // R5: every transaction opens with a START command
    a_r5_open_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (eng_go && eng_op == 3'd0));

    // R10: idle without request stays idle (stray engine completions ignored)
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req) |=> !busy);

endmodule

bind i2c_reg_seq i2c_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .busy   (busy),
    .done   (done),
    .ok     (ok),
    .eng_go (eng_go),
    .eng_op (eng_op)
);

// File: tb/i2c_reg_seq_test.sv
module i2c_reg_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        rd_wr = 1'b0;
    logic [6:0]  addr = '0;
    logic [7:0]  cmd = '0;
    logic [15:0] wdata = '0;
    logic        busy, done, ok;
    logic [15:0] rdata;
    logic        eng_go;
    logic [2:0]  eng_op;
    logic [7:0]  eng_wbyte;
    logic        eng_done = 1'b0;
    logic [2:0]  eng_status = '0;
    logic [7:0]  eng_rbyte = '0;

    i2c_reg_seq uut (
        .clk(clk), .rst_n(rst_n), .req(req), .rd_wr(rd_wr), .addr(addr),
        .cmd(cmd), .wdata(wdata), .busy(busy), .done(done), .ok(ok),
        .rdata(rdata), .eng_go(eng_go), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
        .eng_done(eng_done), .eng_status(eng_status), .eng_rbyte(eng_rbyte)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // engine model controls
    int         lat = 1;
    int         fail_idx = -1;
    bit         first_restart = 0;
    bit         stray = 0;
    bit         done_chk_on = 1;
    logic [7:0] hi_b = '0, lo_b = '0;
    logic [10:0] rec_q[$];
    int         resp_idx = 0;

    task automatic check(input bit cond, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Behavioural byte engine plus per-cycle done/busy reference
    initial begin
        int  pend = 0;
        bit  exp_next = 0;
        bit  exp_now;
        bit  owned = 0;
        logic [2:0] pend_st = '0;
        logic [7:0] pend_b = '0;
        logic [2:0] last_op = 3'd4;
        forever begin
            @(negedge clk);
            exp_now  = exp_next;
            exp_next = 0;
            eng_done = 1'b0;
            if (rst_n && done_chk_on) begin
                // R8: done appears exactly one cycle after terminal event
                check(done == exp_now, "R8", "done timing", done, exp_now);
                if (exp_now) check(!busy, "R8", "busy at done", busy, 0);
            end
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    eng_done   = 1'b1;
                    eng_status = pend_st;
                    eng_rbyte  = pend_b;
                end
            end else if (eng_go) begin
                rec_q.push_back({eng_op, (eng_op == 3'd1) ? eng_wbyte : 8'h00});
                if (eng_op == 3'd4) begin
                    owned = 0;
                    exp_next = 1;
                end else begin
                    pend_b = 8'hFF;
                    case (eng_op)
                        3'd0: begin
                            pend_st = (owned || first_restart) ? 3'd2 : 3'd1;
                            owned = 1;
                        end
                        3'd1: pend_st = (last_op == 3'd0) ? 3'd3 : 3'd4;
                        3'd2: begin pend_st = 3'd5; pend_b = hi_b; end
                        default: begin pend_st = 3'd6; pend_b = lo_b; end
                    endcase
                    if (resp_idx == fail_idx) begin
                        pend_st = (resp_idx == 0) ? 3'd0 : 3'd7;
                        pend_b  = 8'hFF;
                        if (resp_idx == 0) begin
                            exp_next = 0;
                            owned = 0;
                        end
                    end
                    if (resp_idx == fail_idx && resp_idx == 0) begin
                        // done expected one cycle after the bad status is shown
                        pend = lat;
                        resp_idx++;
                        last_op = eng_op;
                        // mark terminal at presentation: handled below via lat
                    end else begin
                        pend = lat;
                        resp_idx++;
                        last_op = eng_op;
                    end
                end
            end else if (stray && !busy) begin
                eng_done   = 1'b1;
                eng_status = 3'd4;
                eng_rbyte  = 8'h77;
                stray      = 0;
            end
            if (eng_done && eng_status == 3'd0) exp_next = 1;
        end
    end

    task automatic run_txn(input bit rd, input logic [6:0] a, input logic [7:0] c,
                           input logic [15:0] w, input logic [7:0] h, input logic [7:0] l,
                           input int fi, input bit frst, input int lt, input bit poke,
                           input string rq);
        logic [10:0] expv[$];
        int n;
        int cyc = 0;
        bit exp_ok;
        logic [15:0] exp_rd;
        rec_q.delete();
        resp_idx = 0;
        fail_idx = fi;
        first_restart = frst;
        lat = lt;
        hi_b = h;
        lo_b = l;
        expv.push_back({3'd0, 8'h00});
        expv.push_back({3'd1, a, 1'b0});
        expv.push_back({3'd1, c});
        if (rd) begin
            expv.push_back({3'd0, 8'h00});
            expv.push_back({3'd1, a, 1'b1});
            expv.push_back({3'd2, 8'h00});
            expv.push_back({3'd3, 8'h00});
        end else begin
            expv.push_back({3'd1, w[15:8]});
            expv.push_back({3'd1, w[7:0]});
        end
        n = (fi < 0) ? expv.size() : fi + 1;
        while (expv.size() > n) void'(expv.pop_back());
        if (fi != 0) expv.push_back({3'd4, 8'h00});
        exp_ok = (fi < 0);
        exp_rd = '0;
        if (rd && (fi < 0 || fi > 5)) exp_rd[15:8] = h;
        if (rd && fi < 0) exp_rd[7:0] = l;

        @(negedge clk);
        req = 1'b1; rd_wr = rd; addr = a; cmd = c; wdata = w;
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            req = 1'b1; rd_wr = ~rd; addr = ~a; cmd = ~c; wdata = ~w;
            repeat (2) @(negedge clk);
            req = 1'b0;
        end
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(exp_ok == ok, rq, "ok", ok, exp_ok);
        check(rdata == exp_rd, rq, "rdata", rdata, exp_rd);
        check(rec_q.size() == expv.size(), rq, "command count", rec_q.size(), expv.size());
        for (int i = 0; i < expv.size() && i < rec_q.size(); i++)
            check(rec_q[i] == expv[i], rq, $sformatf("command %0d", i), rec_q[i], expv[i]);
        repeat (3) @(negedge clk);
        check(rec_q.size() == expv.size(), rq, "no command after done", rec_q.size(), expv.size());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !ok && !eng_go, "R1", "control outputs",
              {busy, done, ok, eng_go}, 0);
        check(rdata == 16'h0, "R1", "rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R2 R7: plain write
        run_txn(0, 7'h5A, 8'h02, 16'hBEEF, 0, 0, -1, 0, 1, 0, "R3");
        // R4 R2 R7 R11: plain read, slower engine
        run_txn(1, 7'h21, 8'h10, 16'h0, 8'hA5, 8'h3C, -1, 0, 3, 0, "R4");
        // R5: opening start reports repeated start, accepted
        run_txn(0, 7'h13, 8'h44, 16'h1234, 0, 0, -1, 1, 2, 0, "R5");
        // R5: opening start fails, no STOP
        run_txn(0, 7'h13, 8'h44, 16'h1234, 0, 0, 0, 0, 1, 0, "R5");
        // R6: address NACK on write
        run_txn(0, 7'h7F, 8'h01, 16'h5555, 0, 0, 1, 0, 1, 0, "R6");
        // R6: last data byte NACK on write
        run_txn(0, 7'h00, 8'hFE, 16'hA0A0, 0, 0, 4, 0, 2, 0, "R6");
        // R6: repeated start step answered wrongly on read
        run_txn(1, 7'h3C, 8'h07, 16'h0, 8'h11, 8'h22, 3, 0, 1, 0, "R6");
        // R11: second read byte fails, first kept
        run_txn(1, 7'h48, 8'h09, 16'h0, 8'hC3, 8'h5E, 6, 0, 1, 0, "R11");
        // R11: first read byte fails, nothing kept
        run_txn(1, 7'h48, 8'h09, 16'h0, 8'hC3, 8'h5E, 5, 0, 2, 0, "R11");
        // R10: new request while busy is ignored
        run_txn(1, 7'h66, 8'h33, 16'h0, 8'h9A, 8'hBC, -1, 0, 2, 1, "R10");
        // R10: stray engine completion while idle is ignored
        stray = 1;
        repeat (4) @(negedge clk);
        check(!busy && !done, "R10", "idle after stray completion", {busy, done}, 0);
        run_txn(0, 7'h2B, 8'h80, 16'h0F0F, 0, 0, -1, 0, 1, 0, "R10");
        // R9: back-to-back read after write with engine latency 4
        run_txn(1, 7'h01, 8'hC0, 16'h0, 8'h00, 8'hFF, -1, 0, 4, 0, "R9");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule